// File: doc/BRIEF.md
# Chainable Serial Input Reader with Status Frame

This block models one industrial digital-input reader that a host polls over a shift-style serial link. A host lowers the shared chip-select line, and at that moment the block takes a snapshot of eight input levels and three supply and temperature flags. While chip select stays low, every rising serial-clock edge moves the snapshot one place towards the serial output, most significant bit first.

A mode input picks the frame that each reader contributes. The short frame is the data byte alone. The long frame is the data byte followed by a status byte. That status byte holds a 5-bit check code of the data byte and the three flags. Once its own frame has left, the reader passes along the bits that arrive on its serial input, one frame later. Several readers can therefore be chained, and the host sees the nearest reader first. A fault output shows whether the supply or temperature alarm is active.

The serial clock and chip select are sampled in the system clock domain. They must be slow enough that each level lasts for at least one system clock.

Top module: `ser_input_reader`

## Requirements
- R1: After reset, with chip select high, `sdo` is 0 and `fault` is 0.
- R2: The data byte and status flags are captured in the system clock cycle that detects chip select going low. Later changes to `din` or the flags do not alter the frame being shifted.
- R3: With `long_mode`=1 the frame is 16 bits: `din[7:0]` first, then a status byte laid out as [7:3] check code, [2] `supply_ok`, [1] `overtemp`, [0] `margin_ok`.
- R4: The check code is the remainder of the data byte times x^5, divided by x^5+x^4+x^2+1. This equals a CRC taken MSB first from an initial value of zero.
- R5: With `long_mode`=0 the frame is the 8 data bits only.
- R6: After its own frame, `sdo` carries the bits received on `sdi`, delayed by exactly one frame length (8 or 16 serial clocks).
- R7: Bits move on each detected rising edge of `sclk` while `cs_n` is low, MSB first. `sdo` is 0 whenever `cs_n` is high.
- R8: `fault` is 1 one system clock after `overtemp`=1 or `supply_ok`=0. `margin_ok` does not affect it.
- R9: A rising `sclk` edge detected in the same cycle as the chip-select fall is ignored. The capture wins, and no bit of the frame is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low, shared by the chain |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial input from the next reader down the chain |
| sdo | output | 1 | Serial output towards the host |
| long_mode | input | 1 | 1 selects the data+status frame, 0 the data-only frame |
| din | input | 8 | Digital input levels |
| supply_ok | input | 1 | 0 signals a supply undervoltage alarm |
| overtemp | input | 1 | 1 signals an overtemperature alarm |
| margin_ok | input | 1 | 0 signals a supply undervoltage warning |
| fault | output | 1 | Alarm summary |

## Verification
Two functions can fall in the same sampled cycle: capture on the chip-select fall, and a shift on a serial-clock rise. The bench provokes this by raising `sclk` on the same system-clock edge at which `cs_n` drops. It then reads the whole frame and requires the data MSB to come out first with every bit present. A second overlap, the forwarding of `sdi` while the frame is still leaving, is judged by comparing the tail of each stream against the pattern that was fed in.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int DATA_W    = 8;
  localparam int CRC_W     = 5;
  localparam int STAT_W    = CRC_W + 3;
  localparam int FRAME_MAX = DATA_W + STAT_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 5'h15;

  typedef struct packed {
    logic [CRC_W-1:0] code;
    logic             supply_ok;
    logic             overtemp;
    logic             margin_ok;
  } status_t;

  // MSB-first bitwise CRC, zero start value
  function automatic logic [CRC_W-1:0] crc_calc(input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/ser_edge_det.sv
module ser_edge_det #(
  parameter logic IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/ser_frame_build.sv
module ser_frame_build
  import ser_pkg::*;
(
  input  logic [DATA_W-1:0]    din_i,
  input  logic                 supply_ok_i,
  input  logic                 overtemp_i,
  input  logic                 margin_ok_i,
  output logic [FRAME_MAX-1:0] frame_o
);
  status_t stat;

  always_comb begin
    stat.code      = crc_calc(din_i);
    stat.supply_ok = supply_ok_i;
    stat.overtemp  = overtemp_i;
    stat.margin_ok = margin_ok_i;
    frame_o        = {din_i, stat};
  end
endmodule

// File: rtl/ser_shift_chain.sv
module ser_shift_chain
  import ser_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 shift_i,
  input  logic                 long_i,
  input  logic [FRAME_MAX-1:0] frame_i,
  input  logic                 sdi_i,
  output logic                 msb_o
);
  localparam int SHORT_IN = FRAME_MAX - DATA_W;

  logic [FRAME_MAX-1:0] sr_q, shifted;
  logic                 long_q;

  always_comb begin
    shifted = {sr_q[FRAME_MAX-2:0], 1'b0};
    if (long_q) shifted[0]        = sdi_i;
    else        shifted[SHORT_IN] = sdi_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= '0;
      long_q <= 1'b1;
    end else if (load_i) begin
      sr_q   <= frame_i;
      long_q <= long_i;
    end else if (shift_i) begin
      sr_q <= shifted;
    end
  end

  assign msb_o = sr_q[FRAME_MAX-1];

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> sr_q == $past(frame_i));
  p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=>
      sr_q[FRAME_MAX-1:SHORT_IN+1] == $past(sr_q[FRAME_MAX-2:SHORT_IN]));
  p_fwd_long_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i && long_q) |=> sr_q[0] == $past(sdi_i));
  p_fwd_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i && !long_q) |=> sr_q[SHORT_IN] == $past(sdi_i));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_i && !load_i) |=> $stable(sr_q));
endmodule

// File: rtl/ser_input_reader.sv
module ser_input_reader
  import ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  input  logic              long_mode,
  input  logic [DATA_W-1:0] din,
  input  logic              supply_ok,
  input  logic              overtemp,
  input  logic              margin_ok,
  output logic              fault
);
  logic                 sclk_rise, sclk_fall_unused;
  logic                 cs_rise_unused, cs_fall;
  logic                 shift_req;
  logic [FRAME_MAX-1:0] frame;
  logic                 msb;
  logic                 fault_q;

  ser_edge_det #(.IDLE(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(sclk),
    .rise_o(sclk_rise), .fall_o(sclk_fall_unused));

  ser_edge_det #(.IDLE(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(cs_n),
    .rise_o(cs_rise_unused), .fall_o(cs_fall));

  ser_frame_build u_frame (
    .din_i(din), .supply_ok_i(supply_ok), .overtemp_i(overtemp),
    .margin_ok_i(margin_ok), .frame_o(frame));

  assign shift_req = sclk_rise & ~cs_n;

  ser_shift_chain u_chain (
    .clk(clk), .rst_n(rst_n), .load_i(cs_fall), .shift_i(shift_req),
    .long_i(long_mode), .frame_i(frame), .sdi_i(sdi), .msb_o(msb));

  always_ff @(posedge clk) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= overtemp | ~supply_ok;
  end

  assign fault = fault_q;
  assign sdo   = msb & ~cs_n;

  p_ot_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp |=> fault);
  p_uv_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> fault);
  p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && sclk_rise) |=> (cs_n || sdo == $past(din[DATA_W-1])));
endmodule

// File: tb/ser_input_reader_tb.sv
module ser_input_reader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic long_mode = 1'b1;
  logic [7:0] din = 8'h00;
  logic supply_ok = 1'b1, overtemp = 1'b0, margin_ok = 1'b1;
  logic sdo, fault;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  ser_input_reader u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .long_mode(long_mode), .din(din), .supply_ok(supply_ok),
    .overtemp(overtemp), .margin_ok(margin_ok), .fault(fault));

  // {long, supply_ok, overtemp, margin_ok, din}
  localparam logic [11:0] VEC [8] = '{
    12'hD00, 12'hDA5, 12'hF3C, 12'h9FF,
    12'hC81, 12'h55A, 12'h70F, 12'h1C3};

  // remainder by polynomial long division, divisor 110101
  function automatic logic [4:0] ref_code(input logic [7:0] d);
    logic [12:0] r;
    r = {d, 5'b0};
    for (int i = 12; i >= 5; i--)
      if (r[i]) r = r ^ (13'b110101 << (i - 5));
    return r[4:0];
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [11:0] v, input logic [7:0] pat,
                      input bit collide, output logic [23:0] got);
    int frame_len;
    frame_len = v[11] ? 16 : 8;
    @(negedge clk);
    long_mode = v[11]; supply_ok = v[10]; overtemp = v[9]; margin_ok = v[8];
    din = v[7:0];
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    if (collide) sclk = 1'b1;
    repeat (3) @(negedge clk);
    din = ~v[7:0]; supply_ok = ~v[10]; overtemp = ~v[9]; // R2 late change
    if (collide) begin sclk = 1'b0; repeat (3) @(negedge clk); end
    got = '0;
    for (int i = 0; i < frame_len + 8; i++) begin
      got[23 - i] = sdo;
      sdi = (i < 8) ? pat[7 - i] : 1'b0;
      sclk = 1'b1; repeat (3) @(negedge clk);
      sclk = 1'b0; repeat (3) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [23:0] expect_stream(input logic [11:0] v, input logic [7:0] pat);
    if (v[11]) return {v[7:0], ref_code(v[7:0]), v[10], v[9], v[8], pat};
    return {v[7:0], pat, 8'h00};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] got;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset sdo", {23'b0, sdo}, 24'h0);
    check("R1 reset fault", {23'b0, fault}, 24'h0);

    for (int k = 0; k < 8; k++) begin
      logic [7:0] pat;
      pat = 8'hA5 ^ 8'(k * 37);
      // R3 R4 R5 R6 R7 R2: full stream per vector
      xfer(VEC[k], pat, 1'b0, got);
      check(VEC[k][11] ? "R3/R4/R6 long frame" : "R5/R6 short frame",
            got, expect_stream(VEC[k], pat));
      check("R7 sdo idle with cs high", {23'b0, sdo}, 24'h0);
      // R8: fault from restored inputs, one clock later
      @(negedge clk);
      supply_ok = VEC[k][10]; overtemp = VEC[k][9]; margin_ok = VEC[k][8];
      repeat (2) @(negedge clk);
      check("R8 fault", {23'b0, fault}, {23'b0, VEC[k][9] | ~VEC[k][10]});
    end

    // R8: warning alone leaves fault low
    @(negedge clk);
    supply_ok = 1'b1; overtemp = 1'b0; margin_ok = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 margin warning only", {23'b0, fault}, 24'h0);

    // R9: capture and sclk rise in the same cycle
    xfer(12'hD96, 8'h3C, 1'b1, got);
    check("R9 collide long", got, expect_stream(12'hD96, 8'h3C));
    xfer(12'h5E1, 8'hC6, 1'b1, got);
    check("R9 collide short", got, expect_stream(12'h5E1, 8'hC6));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule